// File: doc/BRIEF.md
# Main Control Decoder

This block turns the six-bit major opcode of a fixed-width 32-bit instruction word into the control signals that steer a one-cycle datapath. The opcode sits in the top six bits of the instruction. From it the block produces:

- a destination-register select;
- an ALU second-operand select;
- a write-back source select;
- the register-file write enable;
- the data-memory read and write enables;
- a branch-on-equal flag;
- a two-bit ALU operation class that a separate ALU function decoder refines.

The block is purely combinational, and its outputs follow the opcode in the same cycle. Internally, a classifier maps the raw opcode onto one of five named kinds: `KIND_REG`, `KIND_LOAD`, `KIND_STORE`, `KIND_BEQ` and `KIND_NONE`. A generator then expands each kind into a fixed control vector. There is no state, so there are no transitions. Any opcode other than the four recognised values falls into `KIND_NONE`, which drives every output low. A stray encoding therefore writes no register, touches no memory and takes no branch.

Top module: `main_ctrl_decoder`

## Requirements
- R1: With opcode 0 (register-register kind), the outputs are as follows. `dst_sel_rd_o`=1 (the rd field is the destination). `alu_src_imm_o`=0. `wb_from_mem_o`=0. `reg_wr_en_o`=1. `mem_rd_en_o`=0. `mem_wr_en_o`=0. `branch_eq_o`=0. `alu_class_o`=2'b10, meaning the ALU operation comes from the function field.
- R2: With opcode 35 (load word), the outputs are as follows. `dst_sel_rd_o`=0 (the rt field is the destination). `alu_src_imm_o`=1 (the sign-extended offset is the second operand). `wb_from_mem_o`=1. `reg_wr_en_o`=1. `mem_rd_en_o`=1. `mem_wr_en_o`=0. `branch_eq_o`=0. `alu_class_o`=2'b00, meaning add.
- R3: With opcode 43 (store word), the outputs are as follows. `alu_src_imm_o`=1. `mem_wr_en_o`=1. `alu_class_o`=2'b00. Every other output is 0.
- R4: With opcode 4 (branch on equal), the outputs are as follows. `branch_eq_o`=1. `alu_class_o`=2'b01, meaning subtract, so that a zero result signals equality. Every other output is 0.
- R5: Every opcode other than 0, 4, 35 and 43 drives every output, including `alu_class_o`, to 0.
- R6: `reg_wr_en_o` is high exactly for opcodes 0 and 35.
- R7: `mem_rd_en_o` is high only for opcode 35 and `mem_wr_en_o` only for opcode 43, so the two are never high together.
- R8: The outputs depend only on the present opcode. A change of opcode sets the outputs for the new opcode within the same cycle, whatever the previous opcode was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Major opcode, instruction bits 31:26 |
| dst_sel_rd_o | output | 1 | 1 selects rd as the write destination, 0 selects rt |
| alu_src_imm_o | output | 1 | 1 selects the sign-extended immediate as the ALU second operand |
| wb_from_mem_o | output | 1 | 1 selects data-memory read data as the write-back value |
| reg_wr_en_o | output | 1 | Register-file write enable |
| mem_rd_en_o | output | 1 | Data-memory read enable |
| mem_wr_en_o | output | 1 | Data-memory write enable |
| branch_eq_o | output | 1 | Branch-on-equal qualifier |
| alu_class_o | output | 2 | ALU operation class: 00 add, 01 subtract, 10 from function field |

## Verification
The only internal state worth the name is the opcode kind chosen by the classifier. A wrong kind shows at the ports in the same cycle as one of two faults:

- a whole control vector belonging to another instruction;
- an enable raised for an opcode that should be inert.

Sweeping all 64 opcode values and comparing the full nine-bit vector therefore exposes any misclassification straight away. Back-to-back changes between unrelated opcodes show that no earlier value lingers.

// File: rtl/main_ctrl_pkg.sv
package main_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int CLASS_W = 2;

    typedef enum logic [2:0] {
        KIND_NONE  = 3'd0,
        KIND_REG   = 3'd1,
        KIND_LOAD  = 3'd2,
        KIND_STORE = 3'd3,
        KIND_BEQ   = 3'd4
    } op_kind_e;

    localparam logic [CLASS_W-1:0] CLS_ADD   = 2'b00;
    localparam logic [CLASS_W-1:0] CLS_SUB   = 2'b01;
    localparam logic [CLASS_W-1:0] CLS_FUNCT = 2'b10;

    typedef struct packed {
        logic                dst_rd;
        logic                src_imm;
        logic                wb_mem;
        logic                reg_we;
        logic                mem_re;
        logic                mem_we;
        logic                br_eq;
        logic [CLASS_W-1:0]  alu_cls;
    } ctrl_vec_t;

endpackage

// File: rtl/mc_opcode_classify.sv
module mc_opcode_classify
    import main_ctrl_pkg::*;
#(
    parameter int unsigned OPC_REG   = 0,
    parameter int unsigned OPC_LOAD  = 35,
    parameter int unsigned OPC_STORE = 43,
    parameter int unsigned OPC_BEQ   = 4
) (
    input  logic [OPC_W-1:0] opcode_i,
    output op_kind_e         kind_o
);

    localparam logic [OPC_W-1:0] K_REG   = OPC_W'(OPC_REG);
    localparam logic [OPC_W-1:0] K_LOAD  = OPC_W'(OPC_LOAD);
    localparam logic [OPC_W-1:0] K_STORE = OPC_W'(OPC_STORE);
    localparam logic [OPC_W-1:0] K_BEQ   = OPC_W'(OPC_BEQ);

    always_comb begin
        case (opcode_i)
            K_REG:   kind_o = KIND_REG;
            K_LOAD:  kind_o = KIND_LOAD;
            K_STORE: kind_o = KIND_STORE;
            K_BEQ:   kind_o = KIND_BEQ;
            default: kind_o = KIND_NONE;
        endcase
    end

endmodule

// File: rtl/mc_vector_gen.sv
module mc_vector_gen
    import main_ctrl_pkg::*;
(
    input  op_kind_e  kind_i,
    output ctrl_vec_t ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        unique case (kind_i)
            KIND_REG: begin
                ctrl_o.dst_rd  = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.alu_cls = CLS_FUNCT;
            end
            KIND_LOAD: begin
                ctrl_o.src_imm = 1'b1;
                ctrl_o.wb_mem  = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.mem_re  = 1'b1;
                ctrl_o.alu_cls = CLS_ADD;
            end
            KIND_STORE: begin
                ctrl_o.src_imm = 1'b1;
                ctrl_o.mem_we  = 1'b1;
                ctrl_o.alu_cls = CLS_ADD;
            end
            KIND_BEQ: begin
                ctrl_o.br_eq   = 1'b1;
                ctrl_o.alu_cls = CLS_SUB;
            end
            KIND_NONE: begin
                ctrl_o = '0;
            end
            default: begin
                ctrl_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder
    import main_ctrl_pkg::*;
#(
    parameter int unsigned OPC_REG   = 0,
    parameter int unsigned OPC_LOAD  = 35,
    parameter int unsigned OPC_STORE = 43,
    parameter int unsigned OPC_BEQ   = 4
) (
    input  logic [5:0] opcode_i,
    output logic       dst_sel_rd_o,
    output logic       alu_src_imm_o,
    output logic       wb_from_mem_o,
    output logic       reg_wr_en_o,
    output logic       mem_rd_en_o,
    output logic       mem_wr_en_o,
    output logic       branch_eq_o,
    output logic [1:0] alu_class_o
);

    op_kind_e  kind;
    ctrl_vec_t ctrl;

    mc_opcode_classify #(
        .OPC_REG   (OPC_REG),
        .OPC_LOAD  (OPC_LOAD),
        .OPC_STORE (OPC_STORE),
        .OPC_BEQ   (OPC_BEQ)
    ) u_classify (
        .opcode_i (opcode_i),
        .kind_o   (kind)
    );

    mc_vector_gen u_gen (
        .kind_i (kind),
        .ctrl_o (ctrl)
    );

    assign dst_sel_rd_o  = ctrl.dst_rd;
    assign alu_src_imm_o = ctrl.src_imm;
    assign wb_from_mem_o = ctrl.wb_mem;
    assign reg_wr_en_o   = ctrl.reg_we;
    assign mem_rd_en_o   = ctrl.mem_re;
    assign mem_wr_en_o   = ctrl.mem_we;
    assign branch_eq_o   = ctrl.br_eq;
    assign alu_class_o   = ctrl.alu_cls;

    // Guards relating the raw opcode port to the generator's output.
    always_comb begin
        // R6: register write only for the register and load opcodes
        p_regwe_src_r6: assert (!reg_wr_en_o ||
                                opcode_i == 6'(OPC_REG) || opcode_i == 6'(OPC_LOAD))
            else $error("reg write for opcode %0d", opcode_i);
        // R7: memory enables exclusive and tied to their opcodes
        p_mem_excl_r7: assert ($onehot0({mem_rd_en_o, mem_wr_en_o}))
            else $error("read and write both high");
        p_memwe_src_r7: assert (!mem_wr_en_o || opcode_i == 6'(OPC_STORE))
            else $error("mem write for opcode %0d", opcode_i);
        // R4: branch flag comes with a subtract class
        p_br_sub_r4: assert (!branch_eq_o || alu_class_o == CLS_SUB)
            else $error("branch without subtract");
        // R5: unknown opcodes are fully inert
        p_unknown_idle_r5: assert (opcode_i == 6'(OPC_REG) || opcode_i == 6'(OPC_LOAD) ||
                                   opcode_i == 6'(OPC_STORE) || opcode_i == 6'(OPC_BEQ) ||
                                   ctrl == '0)
            else $error("unknown opcode %0d not inert", opcode_i);
    end

endmodule

// File: tb/main_ctrl_decoder_bench.sv
module main_ctrl_decoder_bench;

    // Expected vector order: {dst_rd, src_imm, wb_mem, reg_we, mem_re, mem_we, br_eq, cls[1:0]}
    localparam int NVEC = 4;
    localparam logic [5:0] VEC_OP [NVEC] = '{6'd0, 6'd35, 6'd43, 6'd4};
    localparam logic [8:0] VEC_EXP [NVEC] = '{
        9'b1_0_0_1_0_0_0_10,   // R1 register-register
        9'b0_1_1_1_1_0_0_00,   // R2 load
        9'b0_1_0_0_0_1_0_00,   // R3 store
        9'b0_0_0_0_0_0_1_01    // R4 branch on equal
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [5:0] opcode;
    logic       dst_sel_rd, alu_src_imm, wb_from_mem, reg_wr_en;
    logic       mem_rd_en, mem_wr_en, branch_eq;
    logic [1:0] alu_class;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    main_ctrl_decoder u_main_ctrl_decoder (
        .opcode_i      (opcode),
        .dst_sel_rd_o  (dst_sel_rd),
        .alu_src_imm_o (alu_src_imm),
        .wb_from_mem_o (wb_from_mem),
        .reg_wr_en_o   (reg_wr_en),
        .mem_rd_en_o   (mem_rd_en),
        .mem_wr_en_o   (mem_wr_en),
        .branch_eq_o   (branch_eq),
        .alu_class_o   (alu_class)
    );

    function automatic logic [8:0] expect_for(input logic [5:0] op);
        logic [8:0] e = '0;
        for (int i = 0; i < NVEC; i++)
            if (VEC_OP[i] == op) e = VEC_EXP[i];
        return e;
    endfunction

    function automatic logic [8:0] got_vec();
        return {dst_sel_rd, alu_src_imm, wb_from_mem, reg_wr_en,
                mem_rd_en, mem_wr_en, branch_eq, alu_class};
    endfunction

    task automatic apply(input logic [5:0] op);
        @(posedge clk);
        opcode = op;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: opcode=%0d actual=%b expected=%b", req, opcode, act, exp);
        end
    endtask

    initial begin
        opcode = 6'd63;
        @(negedge clk);
        // Idle state: an unknown opcode at start-up gives an inert vector (R5)
        check("R5", got_vec(), 9'b0);

        // Full sweep over every opcode, table-driven
        for (int op = 0; op < 64; op++) begin
            logic [8:0] e;
            apply(6'(op));
            e = expect_for(6'(op));
            if (op == 0)       check("R1", got_vec(), e);
            else if (op == 35) check("R2", got_vec(), e);
            else if (op == 43) check("R3", got_vec(), e);
            else if (op == 4)  check("R4", got_vec(), e);
            else               check("R5", got_vec(), e);
            // R6: register write exactly for 0 and 35
            check("R6", {8'b0, reg_wr_en}, {8'b0, (op == 0 || op == 35)});
            // R7: memory enables per opcode
            check("R7", {7'b0, mem_rd_en, mem_wr_en}, {7'b0, op == 35, op == 43});
        end

        // R8: back-to-back changes, no carry-over from the previous opcode
        apply(6'd35); check("R8", got_vec(), VEC_EXP[1]);
        apply(6'd36); check("R8", got_vec(), 9'b0);
        apply(6'd43); check("R8", got_vec(), VEC_EXP[2]);
        apply(6'd4);  check("R8", got_vec(), VEC_EXP[3]);
        apply(6'd0);  check("R8", got_vec(), VEC_EXP[0]);
        apply(6'd32); check("R8", got_vec(), 9'b0);

        // Near-miss encodings of recognised opcodes stay inert (R5)
        apply(6'd34); check("R5", got_vec(), 9'b0);
        apply(6'd42); check("R5", got_vec(), 9'b0);
        apply(6'd5);  check("R5", got_vec(), 9'b0);
        apply(6'd1);  check("R5", got_vec(), 9'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule